// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counter channel of a programmable interval timer. It counts input clock ticks from the most recent count load and derives a single output bit from three things: that elapsed count, the programmed count and the selected operating mode. The six modes cover a terminal-count level, a one-shot level, a rate generator, a square wave and two single-tick strobes. No down-counter is used. Each mode is a rule applied to the elapsed count.

A load strobe writes a 16-bit value and a 3-bit mode in one clock cycle and restarts the elapsed count at zero. A gate input is registered and reported in a status snapshot, together with the current mode and the programmed count. The periodic modes do not divide. They keep a second counter that wraps at the programmed count. The elapsed counter saturates at its all-ones value, so a one-time event never happens a second time.

Top module: `pit_channel`

## Requirements
- R1: While reset is asserted and after it is released, the channel is in mode 3 with a programmed count of 65536, and its output is high. The reported gate is high when the channel-index parameter is not 2 and low when it is 2.
- R2: A load stores `load_mode` and the count. A value of 0 is stored as 65536. Both appear on the status outputs in the cycle after the load edge. In that same cycle the elapsed count restarts at 0, even when a load arrives in the middle of a run.
- R3: In mode 0 the output is low while elapsed < count and high once elapsed >= count.
- R4: In mode 1 the output is high while elapsed < count and low from then on.
- R5: In mode 2 the output is high only when elapsed is a nonzero multiple of the count.
- R6: In mode 3 the output is high while (elapsed mod count) < floor((count+1)/2), so an odd count gives a high phase one tick longer than the low phase.
- R7: In modes 4 and 5 the output is high for exactly one tick, when elapsed equals the count, and low at all other times.
- R8: Mode codes 6 and 7 follow the mode 0 rule, and the status output reports the code as written.
- R9: The elapsed count saturates rather than wraps. A mode 1 output that has fallen stays low even after more than 131072 ticks.
- R10: The gate level is registered into the status output one cycle after it changes, and it has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Count-load strobe |
| load_val | input | 16 | Count value to load (0 means 65536) |
| load_mode | input | 3 | Operating mode to load |
| gate | input | 1 | Gate level |
| out | output | 1 | Counter output bit |
| stat_mode | output | 3 | Current mode code |
| stat_gate | output | 1 | Registered gate level |
| stat_count | output | 17 | Programmed count |

## Verification
The hardest case to reach from the ports is proof that the elapsed count saturates. A wrapping 17-bit counter would only show its fault after 131072 ticks. The bench therefore loads mode 1 with count 2, leaves the channel running for more than 131072 cycles, and checks that the output is still low at the points where a wrapped counter would drive it high again. The bench reaches a restart in the middle of a run by issuing a second load two ticks into a mode 0 count. The output must then rise three ticks after the second load, not one tick after it.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        RULE_REACHED,
        RULE_BEFORE,
        RULE_MULTIPLE,
        RULE_SQUARE,
        RULE_EQUAL
    } pit_rule_e;

    function automatic pit_rule_e rule_of(input logic [2:0] m);
        case (m)
            3'd1:    return RULE_BEFORE;
            3'd2:    return RULE_MULTIPLE;
            3'd3:    return RULE_SQUARE;
            3'd4,
            3'd5:    return RULE_EQUAL;
            default: return RULE_REACHED;
        endcase
    endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl #(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       load_mode,
    input  logic             gate,
    output logic [2:0]       mode_o,
    output logic [CNT_W:0]   count_o,
    output logic             gate_o
);
    localparam int REG_W = CNT_W + 1;
    localparam logic [REG_W-1:0] FULL = REG_W'(1) << CNT_W;
    localparam logic GATE_RST = (CHAN_IDX != 2);

    typedef struct packed {
        logic [2:0]       mode;
        logic [REG_W-1:0] count;
        logic             gate;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate;
        if (load) begin
            st_d.mode  = load_mode;
            st_d.count = (load_val == '0) ? FULL : {1'b0, load_val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= 3'd3;
            st_q.count <= FULL;
            st_q.gate  <= GATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign count_o = st_q.count;
    assign gate_o  = st_q.gate;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode_o == 3'd3 && count_o == FULL));

    a_r2_zero_is_full: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> (count_o == FULL));

    a_r2_mode_taken: assert property (@(posedge clk) disable iff (rst)
        load |=> (mode_o == $past(load_mode)));

endmodule

// File: rtl/pit_elapsed.sv
module pit_elapsed #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [CNT_W:0] count_i,
    output logic [CNT_W:0] elapsed_o,
    output logic [CNT_W:0] phase_o
);
    localparam int REG_W = CNT_W + 1;
    localparam logic [REG_W-1:0] SAT = '1;

    typedef struct packed {
        logic [REG_W-1:0] elapsed;
        logic [REG_W-1:0] phase;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.elapsed = '0;
            st_d.phase   = '0;
        end else begin
            st_d.elapsed = (st_q.elapsed == SAT) ? SAT : st_q.elapsed + 1'b1;
            st_d.phase   = (st_q.phase == count_i - 1'b1) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elapsed_o = st_q.elapsed;
    assign phase_o   = st_q.phase;

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> (elapsed_o == '0 && phase_o == '0));

    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (elapsed_o == SAT && !load) |=> (elapsed_o == SAT));

    a_r6_phase_bound: assert property (@(posedge clk) disable iff (rst)
        phase_o < count_i);

endmodule

// File: rtl/pit_outdec.sv
module pit_outdec
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [2:0]     mode_i,
    input  logic [CNT_W:0] count_i,
    input  logic [CNT_W:0] elapsed_i,
    input  logic [CNT_W:0] phase_i,
    output logic           out_o
);
    localparam int REG_W = CNT_W + 1;

    logic [REG_W-1:0] half;
    pit_rule_e        rule;

    always_comb begin
        half = (count_i + 1'b1) >> 1;
        rule = rule_of(mode_i);
        case (rule)
            RULE_BEFORE:   out_o = (elapsed_i < count_i);
            RULE_MULTIPLE: out_o = (phase_i == '0) && (elapsed_i != '0);
            RULE_SQUARE:   out_o = (phase_i < half);
            RULE_EQUAL:    out_o = (elapsed_i == count_i);
            default:       out_o = (elapsed_i >= count_i);
        endcase
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
    parameter int CNT_W    = 16,
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       load_mode,
    input  logic             gate,
    output logic             out,
    output logic [2:0]       stat_mode,
    output logic             stat_gate,
    output logic [CNT_W:0]   stat_count
);
    logic [CNT_W:0] elapsed;
    logic [CNT_W:0] phase;

    pit_ctrl #(.CNT_W(CNT_W), .CHAN_IDX(CHAN_IDX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .load_mode (load_mode),
        .gate      (gate),
        .mode_o    (stat_mode),
        .count_o   (stat_count),
        .gate_o    (stat_gate)
    );

    pit_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .count_i   (stat_count),
        .elapsed_o (elapsed),
        .phase_o   (phase)
    );

    pit_outdec #(.CNT_W(CNT_W)) u_outdec (
        .mode_i    (stat_mode),
        .count_i   (stat_count),
        .elapsed_i (elapsed),
        .phase_i   (phase),
        .out_o     (out)
    );

    a_r3_level_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_mode == 3'd0 && out && !load) |=> out);

    a_r4_stays_low: assert property (@(posedge clk) disable iff (rst)
        (stat_mode == 3'd1 && !out && !load) |=> !out);

    a_r7_single_tick: assert property (@(posedge clk) disable iff (rst)
        ((stat_mode == 3'd4 || stat_mode == 3'd5) && out && !load) |=> !out);

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  load_mode = '0;
    logic        gate = 1'b1;
    logic        out;
    logic [2:0]  stat_mode;
    logic        stat_gate;
    logic [16:0] stat_count;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pit_channel u_pit_channel (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .load_mode(load_mode), .gate(gate), .out(out),
        .stat_mode(stat_mode), .stat_gate(stat_gate), .stat_count(stat_count)
    );

    // mode, value, expected output for elapsed 0..15 (bit d = elapsed d)
    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] val;
        logic [15:0] pat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'd5, 16'b1111_1111_1110_0000},  // R3
        '{3'd0, 16'd0, 16'b0000_0000_0000_0000},  // R3 with count 65536
        '{3'd1, 16'd5, 16'b0000_0000_0001_1111},  // R4
        '{3'd1, 16'd1, 16'b0000_0000_0000_0001},  // R4
        '{3'd2, 16'd4, 16'b0001_0001_0001_0000},  // R5
        '{3'd2, 16'd1, 16'b1111_1111_1111_1110},  // R5
        '{3'd3, 16'd5, 16'b1001_1100_1110_0111},  // R6 odd
        '{3'd3, 16'd4, 16'b0011_0011_0011_0011},  // R6 even
        '{3'd3, 16'd2, 16'b0101_0101_0101_0101},  // R6
        '{3'd3, 16'd1, 16'b1111_1111_1111_1111},  // R6
        '{3'd4, 16'd6, 16'b0000_0000_0100_0000},  // R7
        '{3'd5, 16'd3, 16'b0000_0000_0000_1000},  // R7
        '{3'd6, 16'd2, 16'b1111_1111_1111_1100},  // R8
        '{3'd7, 16'd7, 16'b1111_1111_1000_0000}   // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    // called at a negedge; returns at the negedge where elapsed = 0
    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        load = 1'b1;
        load_mode = m;
        load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(stat_mode), 32'd3);
        chk("R1 count", 32'(stat_count), 32'd65536);
        chk("R1 gate", 32'(stat_gate), 32'd1);
        chk("R1 out", 32'(out), 32'd1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 out after release", 32'(out), 32'd1);
        chk("R1 mode after release", 32'(stat_mode), 32'd3);

        // table walk: R3..R8
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].mode, VECS[i].val);
            chk("R2 mode", 32'(stat_mode), 32'(VECS[i].mode));
            chk("R2 count", 32'(stat_count),
                (VECS[i].val == 0) ? 32'd65536 : 32'(VECS[i].val));
            for (int d = 0; d < 16; d++) begin
                if (d > 0) @(negedge clk);
                chk($sformatf("R3-8 row %0d tick %0d", i, d), 32'(out), 32'(VECS[i].pat[d]));
            end
            @(negedge clk);
        end

        // R2 reload in mid-run restarts elapsed count
        do_load(3'd0, 16'd3);
        @(negedge clk);
        @(negedge clk);
        do_load(3'd0, 16'd3);
        for (int d = 0; d < 4; d++) begin
            if (d > 0) @(negedge clk);
            chk("R2 restart", 32'(out), (d >= 3) ? 32'd1 : 32'd0);
        end

        // R10 gate registered, no effect on waveform
        @(negedge clk);
        gate = 1'b0;
        do_load(3'd3, 16'd4);
        chk("R10 gate low", 32'(stat_gate), 32'd0);
        for (int d = 0; d < 8; d++) begin
            if (d > 0) @(negedge clk);
            chk("R10 waveform", 32'(out), ((d % 4) < 2) ? 32'd1 : 32'd0);
        end
        gate = 1'b1;
        @(negedge clk);
        chk("R10 gate high", 32'(stat_gate), 32'd1);

        // R9 saturation: mode 1, count 2, run past 2^17 ticks
        do_load(3'd1, 16'd2);
        chk("R9 start", 32'(out), 32'd1);
        repeat (131072) @(negedge clk);
        chk("R9 no wrap a", 32'(out), 32'd0);
        @(negedge clk);
        chk("R9 no wrap b", 32'(out), 32'd0);

        summary();
    end
endmodule